// File: doc/BRIEF.md
# RGB to YUV Line-Alternating Packer

This block turns a stream of RGB pixels into a stream of 16-bit words, one word per pixel, for a memory port that is 16 bits wide. Each pixel is converted to luma and two colour-difference values. The conversion uses only integer coefficients, which are the real-valued matrix scaled by 1024 and rounded. The sum of products is divided by 1024 with rounding toward plus infinity at the half point. A fixed offset is then added, and the result is limited to the 10-bit range.

Colour resolution is halved vertically, not horizontally. Every word holds the upper eight bits of the pixel's luma in its high byte. The low byte holds one chroma value, chosen by line parity. The first line of a frame and every other line after it carry the blue-difference value (U). The lines in between carry the red-difference value (V). A receiver rebuilds full colour by pairing two adjacent lines.

Line parity is kept by a two-state machine with the states LP_EVEN and LP_ODD.
- Transition T_FRAME: a valid pixel flagged start-of-frame forces LP_ODD.
- Transition T_LINE: a valid pixel flagged start-of-line alone toggles the state.
- Transition T_HOLD: any other cycle keeps the state.

The flagged pixel itself belongs to the new line. The datapath is three register stages deep: products, sums, then round, offset and clamp.

Top module: `yuv_line_packer`

## Requirements
- R1: After reset `out_valid` is 0. The parity state is LP_EVEN, so valid pixels that arrive before any marker are packed with V.
- R2: Y = ((263·R + 516·G + 100·B + 512) >> 10) + 66. The shift is arithmetic, which gives round-half-up.
- R3: U = ((−152·R − 298·G + 450·B + 512) >> 10) + 512, computed the same way.
- R4: V = ((450·R − 377·G − 73·B + 512) >> 10) + 512, computed the same way.
- R5: Each of Y, U and V is clamped to 0..1023 after the offset is added. This holds for any coefficient and offset parameters.
- R6: The output word is {Y[9:2], C[9:2]}: bits 15:8 hold the luma and bits 7:0 hold the chroma. C is U on odd lines and V on even lines.
- R7: A valid pixel with `pix_sof`=1 starts an odd line, whatever `pix_sol` is and whatever the prior state was. That pixel is packed with U.
- R8: A valid pixel with `pix_sol`=1 and `pix_sof`=0 starts a line of the opposite parity, and that pixel uses the new parity. Pixels without markers keep the parity of the current line.
- R9: When `pix_valid`=0, the markers and pixel values have no effect: no word is emitted and the parity is unchanged.
- R10: A pixel sampled with `pix_valid`=1 at clock edge k gives exactly one word with `out_valid`=1 after edge k+2. This holds for back-to-back pixels and for pixels with gaps between them. No other word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel and markers are valid this cycle |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_r | input | CH_W (10) | Red sample, unsigned |
| pix_g | input | CH_W (10) | Green sample, unsigned |
| pix_b | input | CH_W (10) | Blue sample, unsigned |
| out_valid | output | 1 | Output word valid |
| out_word | output | WORD_W (16) | Packed luma byte and chroma byte |

## Verification
A wrong parity state does not show in the luma byte. It shows only as U and V trading places in the low byte, starting with the first word of the affected line, three cycles after that line's first pixel. The bench therefore uses colours whose U and V differ widely, and it checks the chroma byte of every word rather than only the first word of each line. A broken stage in the valid pipeline shows at the next pixel as a missing word, an extra word, or a word one cycle off. Arithmetic faults in rounding or clamping change only a few codes. These are caught with extreme colours, and with a second instance whose coefficients drive both ends of the clamp.

// File: rtl/yuvpk_pkg.sv
package yuvpk_pkg;

    // Line parity state: odd lines carry U, even lines carry V
    typedef enum logic {
        LP_EVEN = 1'b0,
        LP_ODD  = 1'b1
    } line_par_e;

    // Register stages between pixel input and packed word
    localparam int PIPE_DEPTH = 3;

    // Component lanes
    localparam int N_CMP = 3;
    localparam int CMP_Y = 0;
    localparam int CMP_U = 1;
    localparam int CMP_V = 2;

endpackage

// File: rtl/yuvpk_line_fsm.sv
module yuvpk_line_fsm
    import yuvpk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pix_valid,
    input  logic      pix_sof,
    input  logic      pix_sol,
    output line_par_e line_st,
    output logic      pix_odd
);

    line_par_e st_q;
    line_par_e st_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LP_EVEN;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next state: T_FRAME forces odd, T_LINE toggles, T_HOLD keeps
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            LP_EVEN: begin
                if (pix_valid && (pix_sof || pix_sol)) begin
                    st_nxt = LP_ODD;
                end
            end
            LP_ODD: begin
                if (pix_valid && pix_sof) begin
                    st_nxt = LP_ODD;
                end else if (pix_valid && pix_sol) begin
                    st_nxt = LP_EVEN;
                end
            end
            default: st_nxt = LP_EVEN;
        endcase
    end

    // Outputs: the marked pixel already belongs to the new line
    always_comb begin
        line_st = st_q;
        pix_odd = (st_nxt == LP_ODD);
    end

endmodule

// File: rtl/yuvpk_lane.sv
module yuvpk_lane #(
    parameter int CH_W   = 10,
    parameter int COEF_W = 12,
    parameter int SHIFT  = 10,
    parameter int KR     = 0,
    parameter int KG     = 0,
    parameter int KB     = 0,
    parameter int OFS    = 0
) (
    input  logic                       clk,
    input  logic [2:0][CH_W-1:0]       pix,
    output logic [CH_W-1:0]            res
);

    localparam int PIX_SW = CH_W + 1;
    localparam int PROD_W = PIX_SW + COEF_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam int KV [3] = '{KR, KG, KB};

    localparam logic signed [ACC_W-1:0] RND_K = ACC_W'(2 ** (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] OFS_K = ACC_W'(OFS);
    localparam logic signed [ACC_W-1:0] MAX_K = ACC_W'((2 ** CH_W) - 1);

    logic signed [PROD_W-1:0] prod_q [3];
    logic signed [ACC_W-1:0]  sum_q;
    logic signed [ACC_W-1:0]  scaled;
    logic signed [ACC_W-1:0]  biased;
    logic [CH_W-1:0]          clamped;
    logic [CH_W-1:0]          res_q;

    // Stage 1: one signed product per colour input
    for (genvar i = 0; i < 3; i++) begin : g_mul
        localparam logic signed [COEF_W-1:0] CK = COEF_W'(KV[i]);
        logic signed [PIX_SW-1:0] px_s;
        assign px_s = signed'({1'b0, pix[i]});
        always_ff @(posedge clk) begin
            prod_q[i] <= PROD_W'(px_s) * PROD_W'(CK);
        end
    end

    // Stage 2: accumulate
    always_ff @(posedge clk) begin
        sum_q <= ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2]);
    end

    // Stage 3: round half up, descale, offset, clamp
    always_comb begin
        scaled = (sum_q + RND_K) >>> SHIFT;
        biased = scaled + OFS_K;
        if (biased < 0) begin
            clamped = '0;
        end else if (biased > MAX_K) begin
            clamped = '1;
        end else begin
            clamped = biased[CH_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        res_q <= clamped;
    end

    assign res = res_q;

endmodule

// File: rtl/yuvpk_ctrl_pipe.sv
module yuvpk_ctrl_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_odd,
    output logic out_valid,
    output logic out_odd
);

    logic [DEPTH-1:0] v_q;
    logic [DEPTH-1:0] o_q;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        logic v_d;
        logic o_d;
        if (s == 0) begin : g_head
            assign v_d = in_valid;
            assign o_d = in_odd;
        end else begin : g_body
            assign v_d = v_q[s-1];
            assign o_d = o_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q[s] <= 1'b0;
                o_q[s] <= 1'b0;
            end else begin
                v_q[s] <= v_d;
                o_q[s] <= o_d;
            end
        end
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_odd   = o_q[DEPTH-1];

endmodule

// File: rtl/yuv_line_packer.sv
module yuv_line_packer
    import yuvpk_pkg::*;
#(
    parameter int CH_W   = 10,
    parameter int COEF_W = 12,
    parameter int SHIFT  = 10,
    parameter int WORD_W = 16,
    parameter int Y_KR   = 263,
    parameter int Y_KG   = 516,
    parameter int Y_KB   = 100,
    parameter int Y_OFS  = 66,
    parameter int U_KR   = -152,
    parameter int U_KG   = -298,
    parameter int U_KB   = 450,
    parameter int U_OFS  = 512,
    parameter int V_KR   = 450,
    parameter int V_KG   = -377,
    parameter int V_KB   = -73,
    parameter int V_OFS  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic              pix_sol,
    input  logic [CH_W-1:0]   pix_r,
    input  logic [CH_W-1:0]   pix_g,
    input  logic [CH_W-1:0]   pix_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    localparam int HALF = WORD_W / 2;
    localparam int KTAB [9] = '{Y_KR, Y_KG, Y_KB,
                                U_KR, U_KG, U_KB,
                                V_KR, V_KG, V_KB};
    localparam int OTAB [3] = '{Y_OFS, U_OFS, V_OFS};

    line_par_e            line_st;
    logic                 pix_odd;
    logic                 pipe_odd;
    logic [2:0][CH_W-1:0] pix_vec;
    logic [CH_W-1:0]      res [N_CMP];

    assign pix_vec = {pix_b, pix_g, pix_r};

    yuvpk_line_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_sof   (pix_sof),
        .pix_sol   (pix_sol),
        .line_st   (line_st),
        .pix_odd   (pix_odd)
    );

    for (genvar c = 0; c < N_CMP; c++) begin : g_lane
        yuvpk_lane #(
            .CH_W   (CH_W),
            .COEF_W (COEF_W),
            .SHIFT  (SHIFT),
            .KR     (KTAB[c*3+0]),
            .KG     (KTAB[c*3+1]),
            .KB     (KTAB[c*3+2]),
            .OFS    (OTAB[c])
        ) u_lane (
            .clk (clk),
            .pix (pix_vec),
            .res (res[c])
        );
    end

    yuvpk_ctrl_pipe #(
        .DEPTH (PIPE_DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_valid),
        .in_odd    (pix_odd),
        .out_valid (out_valid),
        .out_odd   (pipe_odd)
    );

    // Luma MSBs high, parity-selected chroma MSBs low
    assign out_word = {res[CMP_Y][CH_W-1 -: HALF],
                       pipe_odd ? res[CMP_U][CH_W-1 -: HALF]
                                : res[CMP_V][CH_W-1 -: HALF]};

    logic unused_lsbs;
    assign unused_lsbs = ^{res[CMP_Y][CH_W-HALF-1:0],
                           res[CMP_U][CH_W-HALF-1:0],
                           res[CMP_V][CH_W-HALF-1:0]};

endmodule

// File: rtl/yuvpk_checker.sv
module yuvpk_checker
    import yuvpk_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              pix_sof,
    input logic              pix_sol,
    input line_par_e         line_st,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word
);

    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= 2'd0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> (out_valid == $past(pix_valid, 3)));

    p_frame_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sof) |=> (line_st == LP_ODD));

    p_line_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sol && !pix_sof) |=> (line_st != $past(line_st)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && (pix_sof || pix_sol)) |=> $stable(line_st));

    p_word_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_word));

endmodule

bind yuv_line_packer yuvpk_checker #(
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_sol   (pix_sol),
    .line_st   (line_st),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/yuv_line_packer_tb.sv
`timescale 1ns/1ps
module yuv_line_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic        pix_sof = 1'b0;
    logic        pix_sol = 1'b0;
    logic [9:0]  pix_r = '0;
    logic [9:0]  pix_g = '0;
    logic [9:0]  pix_b = '0;
    logic        out_valid;
    logic [15:0] out_word;
    logic        clip_valid;
    logic [15:0] clip_word;

    always #2 clk = ~clk;

    yuv_line_packer dut_i (
        .clk (clk), .rst_n (rst_n), .pix_valid (pix_valid),
        .pix_sof (pix_sof), .pix_sol (pix_sol),
        .pix_r (pix_r), .pix_g (pix_g), .pix_b (pix_b),
        .out_valid (out_valid), .out_word (out_word)
    );

    // Coefficients chosen so Y saturates high and U saturates low
    yuv_line_packer #(
        .Y_KR (700), .Y_KG (700), .Y_KB (700), .Y_OFS (66),
        .U_KR (-700), .U_KG (-700), .U_KB (-700), .U_OFS (512)
    ) dut_clip_i (
        .clk (clk), .rst_n (rst_n), .pix_valid (pix_valid),
        .pix_sof (pix_sof), .pix_sol (pix_sol),
        .pix_r (pix_r), .pix_g (pix_g), .pix_b (pix_b),
        .out_valid (clip_valid), .out_word (clip_word)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    exp_q [256];
    string tag_q [256];
    int    wr = 0;
    int    rd = 0;
    bit    b_odd = 1'b0;
    bit    done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int conv(input int kr, kg, kb, ofs, r, g, b);
        int t;
        t = kr * r + kg * g + kb * b + 512;
        t = (t >>> 10) + ofs;
        if (t < 0) t = 0;
        if (t > 1023) t = 1023;
        return t;
    endfunction

    function automatic int pack(input int y, c);
        return ((y >> 2) << 8) | (c >> 2);
    endfunction

    function automatic int exp_main(input int r, g, b, input bit odd);
        int y, u, v;
        y = conv(263, 516, 100, 66, r, g, b);
        u = conv(-152, -298, 450, 512, r, g, b);
        v = conv(450, -377, -73, 512, r, g, b);
        return pack(y, odd ? u : v);
    endfunction

    // Output monitor: every word must match the next expected entry
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd == wr) begin
                n_chk++;
                n_bad++;
                $display("FAIL R10 unexpected word actual=%h expected=none", out_word);
            end else begin
                check(tag_q[rd % 256], int'(out_word), exp_q[rd % 256]);
                rd++;
            end
        end
    end

    task automatic px(input int r, g, b, input bit sof, sol, input string tag);
        pix_valid = 1'b1;
        pix_sof = sof;
        pix_sol = sol;
        pix_r = 10'(r);
        pix_g = 10'(g);
        pix_b = 10'(b);
        if (sof) b_odd = 1'b1;
        else if (sol) b_odd = ~b_odd;
        exp_q[wr % 256] = exp_main(r, g, b, b_odd);
        tag_q[wr % 256] = tag;
        wr++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        pix_valid = 1'b0;
        pix_sof = 1'b0;
        pix_sol = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        idle(5);
        check(tag, wr - rd, 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            check("R1 out_valid after reset", int'(out_valid), 0);
            @(negedge clk);
        end
        px(0, 0, 1023, 1'b0, 1'b0, "R1 pre-marker pixel uses V");
        px(700, 20, 30, 1'b0, 1'b0, "R1 pre-marker pixel uses V");
        drain("R1 word count");
    endtask

    task automatic t_formula();
        px(0, 0, 0, 1'b1, 1'b1, "R2 R3 R6 black odd");
        px(1023, 1023, 1023, 1'b0, 1'b0, "R2 R3 R6 white odd");
        px(1023, 0, 0, 1'b0, 1'b0, "R3 red odd");
        px(0, 1023, 0, 1'b0, 1'b0, "R3 green odd");
        px(0, 0, 1023, 1'b0, 1'b0, "R3 blue odd");
        px(512, 300, 77, 1'b0, 1'b0, "R2 R3 mixed odd");
        px(1, 2, 3, 1'b0, 1'b1, "R4 R6 dark even");
        px(1023, 0, 0, 1'b0, 1'b0, "R4 red even");
        px(0, 1023, 0, 1'b0, 1'b0, "R4 green even");
        px(800, 100, 900, 1'b0, 1'b0, "R4 mixed even");
        px(3, 1019, 511, 1'b0, 1'b0, "R2 R4 rounding even");
        drain("R10 formula word count");
    endtask

    task automatic t_toggle();
        px(0, 0, 1023, 1'b1, 1'b0, "R7 sof alone gives U");
        px(0, 0, 1023, 1'b0, 1'b1, "R8 sol toggles to V");
        px(0, 0, 1023, 1'b0, 1'b0, "R8 unmarked keeps V");
        px(0, 0, 1023, 1'b0, 1'b1, "R8 sol toggles to U");
        px(0, 0, 1023, 1'b1, 1'b1, "R7 sof on odd line stays U");
        px(0, 0, 1023, 1'b0, 1'b1, "R8 sol toggles to V");
        px(0, 0, 1023, 1'b1, 1'b0, "R7 sof from even gives U");
        drain("R10 toggle word count");
    endtask

    task automatic t_ignore();
        px(0, 0, 1023, 1'b1, 1'b0, "R9 setup odd line");
        pix_valid = 1'b0;
        pix_sol = 1'b1;
        pix_sof = 1'b0;
        pix_r = 10'd999;
        @(negedge clk);
        pix_sol = 1'b0;
        pix_sof = 1'b1;
        @(negedge clk);
        pix_sof = 1'b0;
        pix_sol = 1'b1;
        @(negedge clk);
        px(0, 0, 1023, 1'b0, 1'b0, "R9 invalid sol ignored");
        px(0, 0, 1023, 1'b0, 1'b1, "R9 setup even line");
        pix_valid = 1'b0;
        pix_sof = 1'b1;
        @(negedge clk);
        px(0, 0, 1023, 1'b0, 1'b0, "R9 invalid sof ignored");
        drain("R9 no word from invalid cycles");
    endtask

    task automatic t_latency();
        px(100, 200, 300, 1'b1, 1'b0, "R10 single pixel value");
        pix_valid = 1'b0;
        pix_sof = 1'b0;
        check("R10 out_valid one edge after", int'(out_valid), 0);
        @(negedge clk);
        check("R10 out_valid two edges after", int'(out_valid), 0);
        @(negedge clk);
        check("R10 out_valid three edges after", int'(out_valid), 1);
        @(negedge clk);
        check("R10 out_valid four edges after", int'(out_valid), 0);
        drain("R10 single word count");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 24; i++) begin
            px((i * 97) % 1024, (i * 211 + 5) % 1024, (i * 53 + 400) % 1024,
               1'b0, (i % 6) == 0, "R10 back-to-back stream");
            if (i == 13) idle(2);
        end
        drain("R10 stream word count");
    endtask

    task automatic t_clamp();
        int ey, eu, ev;
        px(1023, 1023, 1023, 1'b1, 1'b0, "R5 main instance white");
        pix_valid = 1'b0;
        pix_sof = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ey = conv(700, 700, 700, 66, 1023, 1023, 1023);
        eu = conv(-700, -700, -700, 512, 1023, 1023, 1023);
        check("R5 clip valid", int'(clip_valid), 1);
        check("R5 clamp high Y and low U", int'(clip_word), pack(ey, eu));
        check("R5 clamp expected extremes", pack(ey, eu), 16'hFF00);
        px(0, 0, 0, 1'b0, 1'b1, "R5 main instance black");
        pix_valid = 1'b0;
        pix_sol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ey = conv(700, 700, 700, 66, 0, 0, 0);
        ev = conv(450, -377, -73, 512, 0, 0, 0);
        check("R5 unclamped black even", int'(clip_word), pack(ey, ev));
        drain("R5 word count");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_formula();
        t_toggle();
        t_ignore();
        t_latency();
        t_stream();
        t_clamp();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule